// File: doc/BRIEF.md
# Row Driver Timing Generator

This block drives the row side of a flat panel from the pixel-clock timing stream. It watches the data-enable signal for the end of each active line and switches the row output enable off there. It then waits a programmable guard interval, so the selected row is fully off before the column drivers move to new values. When the guard interval ends, the block issues one column convert strobe, one row shift clock and a row output-enable pulse of programmable width. The row start pulse marks the first row sequence after each rising edge of vertical sync.

Two small settings shape the waveform. A 3-bit guard setting selects `(setting + 1) * 4` pixel clocks of dead time. A 2-bit enable setting selects `(setting + 1) * 8` pixel clocks of row enable. Both settings are captured when a guard interval begins. A line end that arrives while a guard interval is still running is held in a one-deep queue and served after the current enable pulse, so it is never lost.

Top module: `row_drive_timer`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `row_start`, `row_clk`, `row_oe` and `col_strobe` are all low.
- R2: A line end is `line_de` seen high on one rising clock edge and low on the next. From that edge, a guard interval of `(guard_sel + 1) * 4` cycles runs with `row_oe` low. `col_strobe` rises on the edge that ends the interval.
- R3: `col_strobe` is high for exactly one cycle, and only at the end of a guard interval.
- R4: `row_oe` goes high in the same cycle as `col_strobe` and stays high for `(oe_sel + 1) * 8` cycles, unless R7 cuts it short.
- R5: `row_clk` is a one-cycle pulse that coincides with `col_strobe`, so there is one pulse per served line.
- R6: `row_start` is high together with `row_clk` only on the first row sequence that completes after a rising edge of `frame_sync`. It is low on every other sequence.
- R7: A line end that arrives while `row_oe` is high drops `row_oe` on the next cycle and starts a new guard interval at once.
- R8: A line end that arrives during a guard interval is queued, one deep. When the running enable pulse completes, a full guard interval and a strobe follow for the queued line.
- R9: `guard_sel` and `oe_sel` are captured when a guard interval begins. Changing them during that interval does not alter its length or the width of the enable pulse that follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_de | input | 1 | Data enable, high during active pixels |
| frame_sync | input | 1 | Vertical sync; a rising edge arms the row start |
| guard_sel | input | 3 | Guard interval setting, `(n+1)*4` cycles |
| oe_sel | input | 2 | Row enable width setting, `(n+1)*8` cycles |
| row_start | output | 1 | Row start pulse for the first row of a frame |
| row_clk | output | 1 | Row shift clock pulse, one per line |
| row_oe | output | 1 | Row output enable |
| col_strobe | output | 1 | Column latch/convert strobe |

## Verification
The bench sweeps guard and enable settings, including both extremes, and predicts the exact cycle of every strobe and the width of every enable pulse. An off-by-one in the guard or enable count would move the strobe or stretch the pulse by a cycle.

A second line end placed inside the guard interval targets the queue. A design that dropped the queued line would leave an expected strobe unseen. A design that served it at once would strobe a full enable width too early.

A line end during the enable pulse must cut it short. A design that let the enable run on would report a longer width than predicted. Settings changed in mid-guard would, if not captured, give a guard and enable length different from the one predicted. A missing frame-start clear would raise `row_start` on a second line.

// File: rtl/rdt_pkg.sv
// Shared types and helpers for the row driver timing generator.
// Assumes settings are small unsigned codes scaled by a fixed unit.
package rdt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GUARD = 2'd1,
        ST_OE    = 2'd2
    } rdt_state_e;

    // Number of cycles selected by a code: (code + 1) * unit.
    function automatic int scaled_len(input int code, input int unit);
        return (code + 1) * unit;
    endfunction

endpackage

// File: rtl/rdt_edge_det.sv
// Single-bit edge detector. RISE=1 flags a low-to-high change, RISE=0 a
// high-to-low change, between two consecutive rising clock edges.
// Assumes the input is already synchronous to clk.
module rdt_edge_det #(
    parameter bit RISE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic pulse
);

    logic sig_q;

    // Remember the value sampled at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig;
    end

    generate
        if (RISE) begin : g_rise
            // Flag a rising change.
            assign pulse = sig & ~sig_q;
        end else begin : g_fall
            // Flag a falling change.
            assign pulse = ~sig & sig_q;
        end
    endgenerate

endmodule

// File: rtl/rdt_down_counter.sv
// Loadable down-counter that saturates at zero and reports zero.
// Assumes load has priority over decrement.
module rdt_down_counter #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         is_zero
);

    logic [W-1:0] cnt;

    // Load, count down, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt <= '0;
        else if (load)                   cnt <= load_val;
        else if (dec && (cnt != '0))     cnt <= cnt - 1'b1;
    end

    assign is_zero = (cnt == '0);

    // R2: the count holds when neither loaded nor decremented.
    p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !dec) |=> $stable(cnt));

    // R2: a decrement never wraps from zero.
    p_cnt_no_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && dec && cnt == '0) |=> (cnt == '0));

endmodule

// File: rtl/rdt_row_seq.sv
// Row sequencer: turns line-end and frame-start events into a guard
// interval, then a strobe/shift pulse and a row enable window.
// Assumes one line-end event per cycle at most; queue depth is one.
module rdt_row_seq
    import rdt_pkg::*;
#(
    parameter int GUARD_W    = 3,
    parameter int OE_W       = 2,
    parameter int GUARD_UNIT = 4,
    parameter int OE_UNIT    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_end,
    input  logic               frame_rise,
    input  logic [GUARD_W-1:0] guard_sel,
    input  logic [OE_W-1:0]    oe_sel,
    output logic               row_start,
    output logic               row_clk,
    output logic               row_oe,
    output logic               col_strobe
);

    localparam int GUARD_MAX = (2 ** GUARD_W) * GUARD_UNIT;
    localparam int OE_MAX    = (2 ** OE_W) * OE_UNIT;
    localparam int LEN_MAX   = (GUARD_MAX > OE_MAX) ? GUARD_MAX : OE_MAX;
    localparam int CNT_W     = (LEN_MAX > 2) ? $clog2(LEN_MAX) : 1;

    rdt_state_e       state, state_nx;
    logic             cnt_load, cnt_dec, cnt_zero;
    logic [CNT_W-1:0] cnt_val;
    logic [OE_W-1:0]  oe_cap;
    logic             cap_en;
    logic             pend, pend_nx;
    logic             first_pend;
    logic             fire;
    logic [CNT_W-1:0] guard_load, oe_load;

    // Counter reload values derived from the settings.
    assign guard_load = CNT_W'(scaled_len(int'(guard_sel), GUARD_UNIT) - 1);
    assign oe_load    = CNT_W'(scaled_len(int'(oe_cap), OE_UNIT) - 1);

    rdt_down_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .dec      (cnt_dec),
        .is_zero  (cnt_zero)
    );

    // Next-state, counter control and queue update.
    always_comb begin
        state_nx = state;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        cnt_val  = guard_load;
        cap_en   = 1'b0;
        fire     = 1'b0;
        pend_nx  = pend;
        unique case (state)
            ST_IDLE: begin
                if (line_end || pend) begin
                    state_nx = ST_GUARD;
                    cnt_load = 1'b1;
                    cap_en   = 1'b1;
                    pend_nx  = 1'b0;
                end
            end
            ST_GUARD: begin
                if (line_end) pend_nx = 1'b1;
                if (cnt_zero) begin
                    state_nx = ST_OE;
                    cnt_load = 1'b1;
                    cnt_val  = oe_load;
                    fire     = 1'b1;
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            ST_OE: begin
                if (line_end) begin
                    state_nx = ST_GUARD;
                    cnt_load = 1'b1;
                    cap_en   = 1'b1;
                end else if (cnt_zero) begin
                    if (pend) begin
                        state_nx = ST_GUARD;
                        cnt_load = 1'b1;
                        cap_en   = 1'b1;
                        pend_nx  = 1'b0;
                    end else begin
                        state_nx = ST_IDLE;
                    end
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State, queue flag and captured enable width.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            pend   <= 1'b0;
            oe_cap <= '0;
        end else begin
            state <= state_nx;
            pend  <= pend_nx;
            if (cap_en) oe_cap <= oe_sel;
        end
    end

    // Frame-start arming: set by a frame edge, consumed by a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) first_pend <= 1'b0;
        else        first_pend <= frame_rise | (first_pend & ~fire);
    end

    // Registered one-cycle output pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_strobe <= 1'b0;
            row_clk    <= 1'b0;
            row_start  <= 1'b0;
        end else begin
            col_strobe <= fire;
            row_clk    <= fire;
            row_start  <= fire & first_pend;
        end
    end

    assign row_oe = (state == ST_OE);

    // R4: the strobe opens the enable window.
    p_strobe_in_oe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        col_strobe |-> row_oe);

    // R3: the strobe lasts a single cycle.
    p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        col_strobe |=> !col_strobe);

    // R6: row start only rides on a shift pulse.
    p_start_on_clk_r6: assert property (@(posedge clk) disable iff (!rst_n)
        row_start |-> row_clk);

    // R7: a line end during the enable window turns the row off next cycle.
    p_line_end_cuts_oe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (line_end && row_oe) |=> !row_oe);

    // R8: a queued line is served when the enable window completes.
    p_queue_served_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OE && cnt_zero && pend && !line_end) |=> (state == ST_GUARD));

endmodule

// File: rtl/row_drive_timer.sv
// Top of the row driver timing generator. Detects line ends on the data
// enable and frame starts on vertical sync, then hands them to the
// sequencer. Assumes all inputs are synchronous to the pixel clock.
module row_drive_timer #(
    parameter int GUARD_W    = 3,
    parameter int OE_W       = 2,
    parameter int GUARD_UNIT = 4,
    parameter int OE_UNIT    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_de,
    input  logic               frame_sync,
    input  logic [GUARD_W-1:0] guard_sel,
    input  logic [OE_W-1:0]    oe_sel,
    output logic               row_start,
    output logic               row_clk,
    output logic               row_oe,
    output logic               col_strobe
);

    logic line_end;
    logic frame_rise;

    rdt_edge_det #(.RISE(1'b0)) u_de_fall (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   (line_de),
        .pulse (line_end)
    );

    rdt_edge_det #(.RISE(1'b1)) u_vs_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   (frame_sync),
        .pulse (frame_rise)
    );

    rdt_row_seq #(
        .GUARD_W    (GUARD_W),
        .OE_W       (OE_W),
        .GUARD_UNIT (GUARD_UNIT),
        .OE_UNIT    (OE_UNIT)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_end   (line_end),
        .frame_rise (frame_rise),
        .guard_sel  (guard_sel),
        .oe_sel     (oe_sel),
        .row_start  (row_start),
        .row_clk    (row_clk),
        .row_oe     (row_oe),
        .col_strobe (col_strobe)
    );

    // R5: shift pulse and strobe are never apart.
    p_clk_with_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        row_clk == col_strobe);

endmodule

// File: tb/row_drive_timer_bench.sv
module row_drive_timer_bench;

    typedef struct {
        int cyc;
        bit rin;
        int oe;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_de = 1'b0;
    logic       frame_sync = 1'b0;
    logic [2:0] guard_sel = '0;
    logic [1:0] oe_sel = '0;
    logic       row_start, row_clk, row_oe, col_strobe;

    int   cyc = 0;
    int   n_tests = 0;
    int   n_fail = 0;
    exp_t expq[$];
    exp_t cur;
    bit   counting = 1'b0;
    int   oe_cnt = 0;

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    row_drive_timer u_row_drive_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_de    (line_de),
        .frame_sync (frame_sync),
        .guard_sel  (guard_sel),
        .oe_sel     (oe_sel),
        .row_start  (row_start),
        .row_clk    (row_clk),
        .row_oe     (row_oe),
        .col_strobe (col_strobe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int glen(input int g);
        return (g + 1) * 4;
    endfunction

    function automatic int olen(input int o);
        return (o + 1) * 8;
    endfunction

    // Monitor: pops an expectation at each strobe and measures the window.
    always @(negedge clk) begin
        if (rst_n) begin
            if (counting) begin
                if (row_oe) oe_cnt++;
                else begin
                    chk(oe_cnt == cur.oe, "R4/R7 enable width", oe_cnt, cur.oe);
                    counting = 1'b0;
                end
            end
            if (row_clk != col_strobe || (row_start && !col_strobe))
                chk(1'b0, "R5/R6 pulse alignment", int'(row_clk), int'(col_strobe));
            if (col_strobe) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R3 unexpected strobe", cyc, -1);
                end else begin
                    cur = expq.pop_front();
                    chk(cyc == cur.cyc, "R2 strobe cycle", cyc, cur.cyc);
                    chk(row_start == cur.rin, "R6 row start", int'(row_start), int'(cur.rin));
                    chk(row_clk == 1'b1, "R5 shift pulse", int'(row_clk), 1);
                    counting = 1'b1;
                    oe_cnt   = row_oe ? 1 : 0;
                end
            end
        end
    end

    // Driver: one line with active and blank lengths, expectation pushed.
    task automatic run_line(input int act, input int blank, input bit rin);
        exp_t e;
        @(posedge clk); #1 line_de = 1'b1;
        repeat (act) @(posedge clk);
        #1 line_de = 1'b0;
        e.cyc = cyc + 1 + glen(int'(guard_sel));
        e.rin = rin;
        e.oe  = olen(int'(oe_sel));
        expq.push_back(e);
        repeat (blank) @(posedge clk);
    endtask

    task automatic frame_pulse();
        @(posedge clk); #1 frame_sync = 1'b1;
        repeat (2) @(posedge clk);
        #1 frame_sync = 1'b0;
    endtask

    task automatic set_cfg(input int g, input int o);
        @(posedge clk); #1;
        guard_sel = 3'(g);
        oe_sel    = 2'(o);
    endtask

    initial begin
        exp_t e;
        int   e1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs quiet in reset
        chk({row_start, row_clk, row_oe, col_strobe} == 4'b0, "R1 reset outputs",
            int'({row_start, row_clk, row_oe, col_strobe}), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        chk({row_start, row_clk, row_oe, col_strobe} == 4'b0, "R1 after reset",
            int'({row_start, row_clk, row_oe, col_strobe}), 0);

        // R2 R4 R6: smallest settings, frame start then three lines
        set_cfg(0, 0);
        frame_pulse();
        run_line(6, 20, 1'b1);
        run_line(6, 20, 1'b0);
        run_line(6, 20, 1'b0);

        // R2 R4: sweep settings including the maximum
        set_cfg(7, 3);
        run_line(5, 70, 1'b0);
        set_cfg(3, 1);
        run_line(5, 40, 1'b0);
        set_cfg(5, 2);
        frame_pulse();
        run_line(5, 60, 1'b1);

        // R8: second line end inside the guard interval is queued
        set_cfg(2, 0);
        @(posedge clk); #1 line_de = 1'b1;
        repeat (4) @(posedge clk);
        #1 line_de = 1'b0;
        e1 = cyc + 1;
        e.cyc = e1 + 12; e.rin = 1'b0; e.oe = 8;
        expq.push_back(e);
        e.cyc = e1 + 12 + 8 + 12; e.rin = 1'b0; e.oe = 8;
        expq.push_back(e);
        repeat (1) @(posedge clk); #1 line_de = 1'b1;
        repeat (2) @(posedge clk); #1 line_de = 1'b0;
        repeat (60) @(posedge clk);

        // R7: line end during the enable window cuts it short
        set_cfg(0, 3);
        @(posedge clk); #1 line_de = 1'b1;
        repeat (4) @(posedge clk);
        #1 line_de = 1'b0;
        e1 = cyc + 1;
        e.cyc = e1 + 4; e.rin = 1'b0; e.oe = 7;
        expq.push_back(e);
        e.cyc = e1 + 11 + 4; e.rin = 1'b0; e.oe = 32;
        expq.push_back(e);
        repeat (10) @(posedge clk); #1 line_de = 1'b1;
        @(posedge clk); #1 line_de = 1'b0;
        repeat (60) @(posedge clk);

        // R9: settings changed mid-guard do not alter this line
        set_cfg(1, 0);
        @(posedge clk); #1 line_de = 1'b1;
        repeat (4) @(posedge clk);
        #1 line_de = 1'b0;
        e.cyc = cyc + 1 + 8; e.rin = 1'b0; e.oe = 8;
        expq.push_back(e);
        repeat (3) @(posedge clk); #1 guard_sel = 3'd7; oe_sel = 2'd3;
        repeat (60) @(posedge clk);

        // R6: a new frame arms the row start once more
        set_cfg(0, 0);
        frame_pulse();
        run_line(3, 20, 1'b1);
        run_line(3, 20, 1'b0);

        @(negedge clk);
        // R8: every expected strobe was observed
        chk(expq.size() == 0, "R8 all lines served", expq.size(), 0);
        chk(!counting, "R4 window closed", int'(counting), 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule